// File: doc/BRIEF.md
# Three-Wire Frame Transmitter

This block turns one outgoing packet request plus a stream of payload bytes into a complete three-wire transport frame, ready for a UART transmitter. A request names the packet type, a 12-bit payload length, the sequence and acknowledge numbers, and whether a CRC trailer is wanted. The block builds the four-byte packet header, including its checksum, and marks the packet reliable according to its type. It then streams the header, the payload and the optional CRC out with SLIP escaping, and places one delimiter before the frame and one after it.

The output is a byte-wide ready/valid stream. Because a single raw byte may turn into two line bytes, the payload input is stalled while the second byte of an escape pair is waiting to go out. After the closing delimiter has been handed downstream, a one-cycle completion pulse is raised. Picking sequence numbers and holding packets for retransmission are left to the logic around the block.

Top module: `three_wire_tx`

## Requirements
- R1: Every frame begins with one 0xC0 byte and ends with one 0xC0 byte. No other unescaped 0xC0 appears between them.
- R2: Inside a frame, a raw 0xC0 is sent as the pair 0xDB 0xDC and a raw 0xDB is sent as the pair 0xDB 0xDD. Every other byte is sent unchanged. This applies to header, payload and CRC bytes alike.
- R3: Header byte 0 holds the sequence number in bits 2:0, the acknowledge number in bits 5:3, the CRC-present flag in bit 6 and the reliable flag in bit 7.
- R4: Header byte 1 holds the packet type in bits 3:0 and length bits 3:0 in bits 7:4. Header byte 2 holds length bits 11:4.
- R5: Header byte 3 is the bitwise inverse of the low 8 bits of the sum of header bytes 0, 1 and 2.
- R6: Types 1, 2, 4 and 5 are reliable: bit 7 is set and the requested sequence number is used. All other types, including 0 and 15, are sent with bit 7 clear and a sequence field of zero, whatever sequence number was requested.
- R7: When CRC is requested, a 16-bit CRC follows the payload. The CRC is preset to 0xFFFF and is computed LSB-first with the reflected polynomial 0x8408 over the unescaped header and payload bytes. The result is bit-reversed across all 16 bits and sent high byte first. When CRC is not requested, no trailer is sent and bit 6 is clear.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R9: Exactly the requested number of payload bytes is taken. pl_ready is never high while a request could be accepted, so payload bytes offered between frames are left untouched.
- R10: frame_done is high for exactly one cycle. That cycle is the one right after the closing delimiter is accepted downstream. req_ready is high only when no frame is in progress.
- R11: A zero-length request produces only the delimiters, the header and the optional CRC, and takes no payload byte.
- R12: After reset, tx_valid, pl_ready and frame_done are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_type | input | 4 | Packet type |
| req_len | input | 12 | Payload length in bytes |
| req_seq | input | 3 | Sequence number (used only for reliable types) |
| req_ack | input | 3 | Acknowledge number |
| req_crc_en | input | 1 | Append CRC trailer |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken when high together with pl_valid |
| tx_data | output | 8 | Encoded line byte |
| tx_valid | output | 1 | Line byte present |
| tx_ready | input | 1 | Downstream takes the line byte |
| frame_done | output | 1 | One-cycle pulse after the closing delimiter is accepted |

## Verification
The bench targets payload, header and CRC bytes that equal 0xC0 or 0xDB. One case is a type-0 packet of length 12, whose header byte 1 is 0xC0. A design that escaped only the payload would put a bare delimiter in the middle of the frame, and one that dropped the second byte of an escape pair under back-pressure would shorten the stream. Zero-length packets, with and without CRC, are sent with a spare payload byte offered. An off-by-one in the payload count would use that spare byte. A link-control packet sent with a nonzero requested sequence must show a zero sequence field and a clear reliable bit. The CRC trailer is compared against a bit-serial model, so a design that skipped the header bytes, left out the 16-bit reversal or swapped the byte order would miscompare.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;

    localparam int TW_BYTE_W = 8;
    localparam int TW_LEN_W  = 12;
    localparam int TW_NUM_W  = 3;
    localparam int TW_HDR_N  = 4;
    localparam int TW_CRC_W  = 16;

    localparam logic [7:0] SLIP_END     = 8'hC0;
    localparam logic [7:0] SLIP_ESC     = 8'hDB;
    localparam logic [7:0] SLIP_ESC_END = 8'hDC;
    localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;

    typedef struct packed {
        logic [3:0]          ptype;
        logic [TW_LEN_W-1:0] len;
        logic [TW_NUM_W-1:0] seq;
        logic [TW_NUM_W-1:0] ack;
        logic                crc_en;
    } tw_req_t;

    typedef struct packed {
        logic [7:0] data;
        logic       raw;   // sent verbatim, never escaped (delimiters)
        logic       last;  // final byte of the frame
    } tw_sym_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SOF, PH_HDR, PH_PAY, PH_CRC, PH_EOF, PH_DRAIN
    } tw_phase_e;

    function automatic logic tw_is_reliable(input logic [3:0] t);
        return (t == 4'd1) || (t == 4'd2) || (t == 4'd4) || (t == 4'd5);
    endfunction

    function automatic logic tw_needs_escape(input logic [7:0] b);
        return (b == SLIP_END) || (b == SLIP_ESC);
    endfunction

    function automatic logic [7:0] tw_escape_code(input logic [7:0] b);
        return (b == SLIP_END) ? SLIP_ESC_END : SLIP_ESC_ESC;
    endfunction

    // Reflected CRC-16, 0x8408, processed one nibble at a time.
    function automatic logic [15:0] tw_nib_term(input logic [3:0] n);
        return {n, 1'b0, n, 3'b000, n};
    endfunction

    function automatic logic [15:0] tw_crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        r = (r >> 4) ^ tw_nib_term(r[3:0] ^ d[3:0]);
        r = (r >> 4) ^ tw_nib_term(r[3:0] ^ d[7:4]);
        return r;
    endfunction

    function automatic logic [15:0] tw_rev16(input logic [15:0] x);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = x[15-i];
        return r;
    endfunction

endpackage

// File: rtl/tw_hdr_build.sv
`timescale 1ns/1ps
module tw_hdr_build
    import tw_pkg::*;
(
    input  tw_req_t                      req,
    output logic [TW_HDR_N-1:0][7:0]     hdr
);
    logic       rel;
    logic [7:0] sum3;

    always_comb begin
        rel    = tw_is_reliable(req.ptype);
        hdr[0] = {rel, req.crc_en, req.ack, (rel ? req.seq : {TW_NUM_W{1'b0}})};
        hdr[1] = {req.len[3:0], req.ptype};
        hdr[2] = req.len[TW_LEN_W-1:4];
        sum3   = hdr[0] + hdr[1] + hdr[2];
        hdr[3] = ~sum3;
    end
endmodule

// File: rtl/tw_crc16.sv
`timescale 1ns/1ps
module tw_crc16
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init,
    input  logic                 upd,
    input  logic [7:0]           din,
    output logic [TW_CRC_W-1:0]  crc_tx
);
    logic [TW_CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_PRESET;
        else if (upd)    crc_q <= tw_crc_step(crc_q, din);
    end

    assign crc_tx = tw_rev16(crc_q);
endmodule

// File: rtl/tw_slip_enc.sv
`timescale 1ns/1ps
module tw_slip_enc
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tw_sym_t    in_sym,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_last
);
    logic       ov_q, ol_q, pend_q, plast_q;
    logic [7:0] od_q, pbyte_q;
    logic       esc;

    assign in_ready = !ov_q || (out_ready && !pend_q);
    assign esc      = !in_sym.raw && tw_needs_escape(in_sym.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q    <= 1'b0;
            ol_q    <= 1'b0;
            pend_q  <= 1'b0;
            plast_q <= 1'b0;
            od_q    <= '0;
            pbyte_q <= '0;
        end else if (ov_q && out_ready && pend_q) begin
            od_q   <= pbyte_q;
            ol_q   <= plast_q;
            pend_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            ov_q <= 1'b1;
            if (esc) begin
                od_q    <= SLIP_ESC;
                ol_q    <= 1'b0;
                pbyte_q <= tw_escape_code(in_sym.data);
                plast_q <= in_sym.last;
                pend_q  <= 1'b1;
            end else begin
                od_q   <= in_sym.data;
                ol_q   <= in_sym.last;
                pend_q <= 1'b0;
            end
        end else if (ov_q && out_ready) begin
            ov_q <= 1'b0;
        end
    end

    assign out_data  = od_q;
    assign out_valid = ov_q;
    assign out_last  = ol_q;
endmodule

// File: rtl/three_wire_tx.sv
`timescale 1ns/1ps
module three_wire_tx
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [3:0]           req_type,
    input  logic [TW_LEN_W-1:0]  req_len,
    input  logic [TW_NUM_W-1:0]  req_seq,
    input  logic [TW_NUM_W-1:0]  req_ack,
    input  logic                 req_crc_en,
    input  logic [7:0]           pl_data,
    input  logic                 pl_valid,
    output logic                 pl_ready,
    output logic [7:0]           tx_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic                 frame_done
);
    localparam int IDX_W = $clog2(TW_HDR_N);

    tw_phase_e                 ph_q;
    tw_req_t                   rq_q;
    logic [IDX_W-1:0]          idx_q;
    logic [TW_LEN_W-1:0]       left_q;
    logic                      done_q;

    logic [TW_HDR_N-1:0][7:0]  hdr;
    logic [TW_CRC_W-1:0]       crc_tx;
    tw_sym_t                   sym;
    logic                      sym_valid;
    logic                      enc_ready;
    logic                      tx_last;
    logic                      accept, push, crc_upd, tx_end;

    assign req_ready = (ph_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign pl_ready  = (ph_q == PH_PAY) && enc_ready;
    assign push      = sym_valid && enc_ready;
    assign crc_upd   = push && ((ph_q == PH_HDR) || (ph_q == PH_PAY));
    assign tx_end    = tx_valid && tx_ready && tx_last;

    tw_hdr_build u_hdr (
        .req (rq_q),
        .hdr (hdr)
    );

    tw_crc16 u_crc (
        .clk    (clk),
        .rst    (rst),
        .init   (accept),
        .upd    (crc_upd),
        .din    (sym.data),
        .crc_tx (crc_tx)
    );

    tw_slip_enc u_enc (
        .clk       (clk),
        .rst       (rst),
        .in_sym    (sym),
        .in_valid  (sym_valid),
        .in_ready  (enc_ready),
        .out_data  (tx_data),
        .out_valid (tx_valid),
        .out_ready (tx_ready),
        .out_last  (tx_last)
    );

    always_comb begin
        sym       = '0;
        sym_valid = 1'b0;
        case (ph_q)
            PH_SOF: begin
                sym.data  = SLIP_END;
                sym.raw   = 1'b1;
                sym_valid = 1'b1;
            end
            PH_HDR: begin
                sym.data  = hdr[idx_q];
                sym_valid = 1'b1;
            end
            PH_PAY: begin
                sym.data  = pl_data;
                sym_valid = pl_valid;
            end
            PH_CRC: begin
                sym.data  = idx_q[0] ? crc_tx[7:0] : crc_tx[15:8];
                sym_valid = 1'b1;
            end
            PH_EOF: begin
                sym.data  = SLIP_END;
                sym.raw   = 1'b1;
                sym.last  = 1'b1;
                sym_valid = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            rq_q   <= '0;
            idx_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= tx_end;
            case (ph_q)
                PH_IDLE: if (accept) begin
                    rq_q.ptype  <= req_type;
                    rq_q.len    <= req_len;
                    rq_q.seq    <= req_seq;
                    rq_q.ack    <= req_ack;
                    rq_q.crc_en <= req_crc_en;
                    ph_q        <= PH_SOF;
                end
                PH_SOF: if (push) begin
                    ph_q  <= PH_HDR;
                    idx_q <= '0;
                end
                PH_HDR: if (push) begin
                    if (idx_q == IDX_W'(TW_HDR_N - 1)) begin
                        idx_q <= '0;
                        if (rq_q.len == '0) ph_q <= rq_q.crc_en ? PH_CRC : PH_EOF;
                        else begin
                            ph_q   <= PH_PAY;
                            left_q <= rq_q.len;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_PAY: if (push) begin
                    left_q <= left_q - 1'b1;
                    if (left_q == TW_LEN_W'(1)) begin
                        idx_q <= '0;
                        ph_q  <= rq_q.crc_en ? PH_CRC : PH_EOF;
                    end
                end
                PH_CRC: if (push) begin
                    if (idx_q[0]) ph_q <= PH_EOF;
                    else          idx_q <= idx_q + 1'b1;
                end
                PH_EOF:   if (push)   ph_q <= PH_DRAIN;
                PH_DRAIN: if (tx_end) ph_q <= PH_IDLE;
                default:              ph_q <= PH_IDLE;
            endcase
        end
    end

    assign frame_done = done_q;
endmodule

// File: rtl/tw_tx_checker.sv
`timescale 1ns/1ps
module tw_tx_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       pl_ready,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       frame_done
);
    logic esc_q;

    always_ff @(posedge clk) begin
        if (rst) esc_q <= 1'b0;
        else if (tx_valid && tx_ready) esc_q <= (tx_data == 8'hDB);
    end

    // R8: a stalled byte is held
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R2: an escape introducer is always followed by one of the two codes
    a_r2_escape_pair: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && esc_q |-> (tx_data == 8'hDC) || (tx_data == 8'hDD));

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R10: completion follows an accepted delimiter
    a_r10_done_after_end: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(tx_valid && tx_ready && tx_data == 8'hC0));

    // R9: payload is never taken while a request could be accepted
    a_r9_payload_gated: assert property (@(posedge clk) disable iff (rst)
        pl_ready |-> !req_ready);
endmodule

bind three_wire_tx tw_tx_checker u_tw_tx_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .pl_ready   (pl_ready),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .frame_done (frame_done)
);

// File: tb/three_wire_tx_test.sv
`timescale 1ns/1ps
module three_wire_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_type = '0;
    logic [11:0] req_len = '0;
    logic [2:0]  req_seq = '0;
    logic [2:0]  req_ack = '0;
    logic        req_crc_en = 1'b0;
    logic [7:0]  pl_data = '0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        frame_done;

    always #2.5 clk = ~clk;

    three_wire_tx uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_len(req_len), .req_seq(req_seq),
        .req_ack(req_ack), .req_crc_en(req_crc_en),
        .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .frame_done(frame_done)
    );

    int         errors = 0;
    int         checks = 0;
    logic [7:0] exp_b[$];
    string      exp_t[$];
    bit         exp_l[$];
    logic [7:0] pl_q[$];
    logic [7:0] cur_pay[$];
    int         rdy_mode = 0;
    bit         exp_done = 0;
    bit         stall_chk = 0;
    logic [7:0] stall_data = '0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic push_line(input logic [7:0] b, input string tag, input bit last);
        exp_b.push_back(b); exp_t.push_back(tag); exp_l.push_back(last);
    endtask

    task automatic push_esc(input logic [7:0] b, input string tag);
        if (b == 8'hC0) begin push_line(8'hDB, tag, 0); push_line(8'hDC, tag, 0); end
        else if (b == 8'hDB) begin push_line(8'hDB, tag, 0); push_line(8'hDD, tag, 0); end
        else push_line(b, tag, 0);
    endtask

    task automatic expect_frame(input logic [3:0] t, input logic [11:0] len,
                                input logic [2:0] s, input logic [2:0] a, input bit c);
        logic [7:0]  h [4];
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] rv;
        bit rel = (t == 1) || (t == 2) || (t == 4) || (t == 5);
        string t0 = rel ? "R3" : "R6";
        string tz = (len == 0) ? "R11" : "";
        h[0] = {rel, c, a, rel ? s : 3'd0};
        h[1] = {len[3:0], t};
        h[2] = len[11:4];
        h[3] = ~(h[0] + h[1] + h[2]);
        push_line(8'hC0, "R1", 0);
        push_esc(h[0], tz != "" ? tz : t0);
        push_esc(h[1], tz != "" ? tz : "R4");
        push_esc(h[2], tz != "" ? tz : "R4");
        push_esc(h[3], tz != "" ? tz : "R5");
        for (int i = 0; i < 4; i++) crc = ref_crc(crc, h[i]);
        foreach (cur_pay[i]) begin
            push_esc(cur_pay[i], "R2");
            crc = ref_crc(crc, cur_pay[i]);
        end
        if (c) begin
            for (int i = 0; i < 16; i++) rv[i] = crc[15-i];
            push_esc(rv[15:8], "R7");
            push_esc(rv[7:0], "R7");
        end
        push_line(8'hC0, "R1", 1);
    endtask

    task automatic send(input logic [3:0] t, input logic [11:0] len, input logic [2:0] s,
                        input logic [2:0] a, input bit c, input bit extra);
        expect_frame(t, len, s, a, c);
        foreach (cur_pay[i]) pl_q.push_back(cur_pay[i]);
        if (extra) pl_q.push_back(8'hAA);
        @(negedge clk);
        req_type = t; req_len = len; req_seq = s; req_ack = a; req_crc_en = c;
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_b.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (extra) begin
            chk(pl_q.size() == 1 && !pl_ready, (len == 0) ? "R11" : "R9",
                "spare payload byte left untouched", pl_q.size(), 1);
            pl_q.delete();
        end
    endtask

    // driver of ready/payload and scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_chk) begin
                chk(tx_valid && tx_data == stall_data, "R8", "stalled byte held", tx_data, stall_data);
                stall_chk = 0;
            end
            tx_ready = (rdy_mode == 0) ? 1'b1 : 1'($urandom % 2);
            pl_valid = (pl_q.size() > 0) && (rdy_mode == 0 || ($urandom % 4) != 0);
            pl_data  = (pl_q.size() > 0) ? pl_q[0] : 8'h00;
            #1;
            if (exp_done || frame_done) begin
                chk(frame_done == exp_done, "R10", "done pulse", frame_done, exp_done);
                exp_done = 0;
            end
            if (tx_valid && tx_ready) begin
                if (exp_b.size() == 0) begin
                    chk(0, "R1", "unexpected line byte", tx_data, 0);
                end else begin
                    chk(tx_data == exp_b[0], exp_t[0], "line byte", tx_data, exp_b[0]);
                    if (exp_l[0]) exp_done = 1;
                    void'(exp_b.pop_front()); void'(exp_t.pop_front()); void'(exp_l.pop_front());
                end
            end else if (tx_valid) begin
                stall_chk  = 1;
                stall_data = tx_data;
            end
            if (pl_valid && pl_ready) void'(pl_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!tx_valid && !pl_ready && !frame_done && req_ready, "R12", "reset state",
            {tx_valid, pl_ready, frame_done, req_ready}, 4'b0001);

        // reliable command, no CRC, spare byte offered
        cur_pay = '{8'h11, 8'h22, 8'h33};
        send(4'd1, 12'd3, 3'd5, 3'd2, 1'b0, 1'b1);

        // ACL with CRC and bytes needing escapes
        cur_pay = '{8'hC0, 8'hDB, 8'h7E, 8'h00};
        send(4'd2, 12'd4, 3'd7, 3'd7, 1'b1, 1'b0);

        // link control: sequence forced to zero, unreliable
        cur_pay = '{8'h01, 8'h7E};
        send(4'd15, 12'd2, 3'd3, 3'd1, 1'b0, 1'b0);

        // zero-length acknowledgement with CRC, spare byte offered
        cur_pay.delete();
        send(4'd0, 12'd0, 3'd6, 3'd4, 1'b1, 1'b1);

        // zero-length event without CRC
        send(4'd4, 12'd0, 3'd2, 3'd0, 1'b0, 1'b1);

        // header byte 1 becomes 0xC0 and must be escaped
        rdy_mode = 1;
        cur_pay.delete();
        for (int i = 0; i < 12; i++) cur_pay.push_back(8'(i * 29 + 3));
        send(4'd0, 12'd12, 3'd0, 3'd0, 1'b1, 1'b0);

        // ISO packet under random back-pressure with many escapes
        cur_pay.delete();
        for (int i = 0; i < 16; i++)
            cur_pay.push_back((i % 5 == 0) ? 8'hC0 : (i % 5 == 1) ? 8'hDB : 8'(i * 13));
        send(4'd5, 12'd16, 3'd4, 3'd6, 1'b1, 1'b1);

        // escape-heavy frame without CRC under back-pressure
        cur_pay = '{8'hDB, 8'hDB, 8'hC0, 8'hC0, 8'hDC, 8'hDD};
        send(4'd4, 12'd6, 3'd1, 3'd3, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule